// File: doc/BRIEF.md
# DRAM Controller and PHY Reset Sequencer

This block brings a DRAM protocol controller and its PHY out of reset in a fixed order after one start request. A start pulse forces every reset it drives back to the asserted state. The block then releases the resets one stage at a time:

- the two PHY soft-reset bits first;
- the two controller soft-reset bits after a fixed gap;
- the PHY's internal analog reset;
- last, the PHY's internal digital reset.

The gap between the analog and digital releases is counted in DRAM clock cycles. A pulse on `dram_tick_i` marks each DRAM cycle, so the gap stays correct whatever the ratio between the local clock and the DRAM clock. The other gaps are counted in local clock cycles.

Reset outputs are active high: 1 means the reset is held. The analog and digital outputs are release flags: 1 means that reset is released. All pins are plain control and status levels. There is no data stream, so there is no handshake and no back-pressure.

Top module: `ddr_rst_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first start, `ctl_rst_o` and `phy_rst_o` are 2'b11, `phy_ana_rel_o`, `phy_dig_rel_o` and `ready_o` are 0, and `dram_tick_i` has no effect.
- R2: A high `start_i` sampled on any clock edge, in any phase, makes the next cycle show `ctl_rst_o`=2'b11, `phy_rst_o`=2'b11, both release flags 0 and `ready_o` 0. This holds for as long as `start_i` stays high.
- R3: After the last cycle with `start_i` high, all resets stay asserted for exactly HOLD_CYC cycles. Then both PHY reset bits drop to 2'b00 together.
- R4: `ctl_rst_o` stays 2'b11 whenever `phy_rst_o` is not 2'b00. It drops to 2'b00 exactly PHY2CTL_CYC cycles after `phy_rst_o` dropped.
- R5: After the controller release, both release flags stay 0 for exactly SETTLE_CYC cycles. Then `phy_ana_rel_o` rises.
- R6: `phy_dig_rel_o` rises on the edge that samples the ANA2DIG_TICKS-th high `dram_tick_i` seen while only the analog reset is released. The gap depends on ticks, not on local cycles.
- R7: `phy_dig_rel_o` is never 1 while `phy_ana_rel_o` is 0.
- R8: `ready_o` rises together with `phy_dig_rel_o`. It then holds, with every other output unchanged and `dram_tick_i` ignored, until the next start.
- R9: With no `dram_tick_i` pulses, the sequence waits with only the analog reset released and never releases the digital reset.
- R10: A start arriving during the sequence, or after `ready_o`, restarts the whole sequence from the hold phase with full-length gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts or restarts the sequence |
| dram_tick_i | input | 1 | One pulse per DRAM clock cycle |
| ctl_rst_o | output | 2 | Controller soft resets, 1 = held |
| phy_rst_o | output | 2 | PHY soft resets, 1 = held |
| phy_ana_rel_o | output | 1 | PHY analog reset released |
| phy_dig_rel_o | output | 1 | PHY digital reset released |
| ready_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with HOLD_CYC=3, PHY2CTL_CYC=5, SETTLE_CYC=2 and ANA2DIG_TICKS=6. With these values every phase length can be counted exactly within a few dozen cycles. The tick-counted gap can also be run with tick spacings of 1, 2, 3 and 5 local cycles, which shows that it counts pulses and not cycles. The small limits also make it cheap to restart the sequence in the hold, PHY-gap, analog-wait and done phases, and to stall the analog-wait phase indefinitely with no ticks.

// File: rtl/ddr_rst_seq_pkg.sv
package ddr_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOLD   = 3'd1,
    ST_PHY_UP = 3'd2,
    ST_CTL_UP = 3'd3,
    ST_ANA_UP = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic [1:0] ctl_rst;
    logic [1:0] phy_rst;
    logic       ana_rel;
    logic       dig_rel;
    logic       ready;
  } pin_set_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ddr_rst_seq_cnt.sv
module ddr_rst_seq_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  // hit marks the last counted step before the limit is reached
  assign hit = step && (cnt_q == (lim - W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/ddr_rst_seq_fsm.sv
module ddr_rst_seq_fsm
  import ddr_rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tmr_hit,
  input  logic       tck_hit,
  output seq_state_t state,
  output logic       advance
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    advance = 1'b0;
    if (start) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:   if (tmr_hit) begin state_d = ST_PHY_UP; advance = 1'b1; end
        ST_PHY_UP: if (tmr_hit) begin state_d = ST_CTL_UP; advance = 1'b1; end
        ST_CTL_UP: if (tmr_hit) begin state_d = ST_ANA_UP; advance = 1'b1; end
        ST_ANA_UP: if (tck_hit) begin state_d = ST_DONE;   advance = 1'b1; end
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/ddr_rst_seq_outdec.sv
module ddr_rst_seq_outdec
  import ddr_rst_seq_pkg::*;
(
  input  seq_state_t state,
  output pin_set_t   pins
);

  always_comb begin
    unique case (state)
      ST_PHY_UP: pins = '{ctl_rst: 2'b11, phy_rst: 2'b00, ana_rel: 1'b0, dig_rel: 1'b0, ready: 1'b0};
      ST_CTL_UP: pins = '{ctl_rst: 2'b00, phy_rst: 2'b00, ana_rel: 1'b0, dig_rel: 1'b0, ready: 1'b0};
      ST_ANA_UP: pins = '{ctl_rst: 2'b00, phy_rst: 2'b00, ana_rel: 1'b1, dig_rel: 1'b0, ready: 1'b0};
      ST_DONE:   pins = '{ctl_rst: 2'b00, phy_rst: 2'b00, ana_rel: 1'b1, dig_rel: 1'b1, ready: 1'b1};
      default:   pins = '{ctl_rst: 2'b11, phy_rst: 2'b11, ana_rel: 1'b0, dig_rel: 1'b0, ready: 1'b0};
    endcase
  end

endmodule

// File: rtl/ddr_rst_seq.sv
module ddr_rst_seq
  import ddr_rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC      = 16,
  parameter int unsigned PHY2CTL_CYC   = 64,
  parameter int unsigned SETTLE_CYC    = 8,
  parameter int unsigned ANA2DIG_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dram_tick_i,
  output logic [1:0] ctl_rst_o,
  output logic [1:0] phy_rst_o,
  output logic       phy_ana_rel_o,
  output logic       phy_dig_rel_o,
  output logic       ready_o
);

  localparam int unsigned TMR_MAX = max3(HOLD_CYC, PHY2CTL_CYC, SETTLE_CYC);
  localparam int unsigned TW      = $clog2(TMR_MAX + 1);
  localparam int unsigned KW      = $clog2(ANA2DIG_TICKS + 1);

  seq_state_t state;
  pin_set_t   pins;
  logic       advance, clr;
  logic       tmr_step, tmr_hit, tck_step, tck_hit;
  logic [TW-1:0] tmr_lim;

  assign clr = start_i | advance;

  always_comb begin
    tmr_step = 1'b1;
    unique case (state)
      ST_HOLD:   tmr_lim = TW'(HOLD_CYC);
      ST_PHY_UP: tmr_lim = TW'(PHY2CTL_CYC);
      ST_CTL_UP: tmr_lim = TW'(SETTLE_CYC);
      default: begin
        tmr_lim  = TW'(TMR_MAX);
        tmr_step = 1'b0;
      end
    endcase
  end

  assign tck_step = dram_tick_i && (state == ST_ANA_UP);

  ddr_rst_seq_cnt #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(tmr_step),
    .lim(tmr_lim), .hit(tmr_hit)
  );

  ddr_rst_seq_cnt #(.W(KW)) u_tck (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(tck_step),
    .lim(KW'(ANA2DIG_TICKS)), .hit(tck_hit)
  );

  ddr_rst_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i),
    .tmr_hit(tmr_hit), .tck_hit(tck_hit),
    .state(state), .advance(advance)
  );

  ddr_rst_seq_outdec u_dec (
    .state(state), .pins(pins)
  );

  assign ctl_rst_o     = pins.ctl_rst;
  assign phy_rst_o     = pins.phy_rst;
  assign phy_ana_rel_o = pins.ana_rel;
  assign phy_dig_rel_o = pins.dig_rel;
  assign ready_o       = pins.ready;

endmodule

// File: rtl/ddr_rst_seq_checker.sv
module ddr_rst_seq_checker #(
  parameter int unsigned PHY2CTL_CYC   = 64,
  parameter int unsigned ANA2DIG_TICKS = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       dram_tick_i,
  input logic [1:0] ctl_rst_o,
  input logic [1:0] phy_rst_o,
  input logic       phy_ana_rel_o,
  input logic       phy_dig_rel_o,
  input logic       ready_o
);

  int unsigned gap_cnt;
  int unsigned tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= 0;
      tick_cnt <= 0;
    end else begin
      gap_cnt  <= (phy_rst_o == 2'b00 && ctl_rst_o == 2'b11) ? gap_cnt + 1 : 0;
      tick_cnt <= (phy_ana_rel_o && !phy_dig_rel_o)
                  ? tick_cnt + (dram_tick_i ? 1 : 0) : 0;
    end
  end

  AST_START_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ctl_rst_o == 2'b11 && phy_rst_o == 2'b11 &&
                 !phy_ana_rel_o && !phy_dig_rel_o && !ready_o)); // R2
  AST_PHY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phy_rst_o) != 1); // R3
  AST_PHY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rst_o != 2'b00) |-> (ctl_rst_o == 2'b11)); // R4
  AST_CTL_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rst_o) == 2'b11 && ctl_rst_o == 2'b00) |-> (gap_cnt >= PHY2CTL_CYC)); // R4
  AST_ANA_AFTER_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ana_rel_o |-> (ctl_rst_o == 2'b00)); // R5
  AST_DIG_TICKS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_dig_rel_o) |-> (tick_cnt >= ANA2DIG_TICKS)); // R6
  AST_ANA_BEFORE_DIG: assert property (@(posedge clk) disable iff (!rst_n)
    phy_dig_rel_o |-> phy_ana_rel_o); // R7
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> ready_o); // R8

endmodule

bind ddr_rst_seq ddr_rst_seq_checker #(
  .PHY2CTL_CYC(PHY2CTL_CYC), .ANA2DIG_TICKS(ANA2DIG_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dram_tick_i(dram_tick_i),
  .ctl_rst_o(ctl_rst_o), .phy_rst_o(phy_rst_o), .phy_ana_rel_o(phy_ana_rel_o),
  .phy_dig_rel_o(phy_dig_rel_o), .ready_o(ready_o)
);

// File: tb/ddr_rst_seq_test.sv
`timescale 1ns/1ps
module ddr_rst_seq_test;

  localparam int HOLD = 3, GAP = 5, SETTLE = 2, TICKS = 6;
  localparam int NPER = 4;
  localparam int PERIODS [NPER] = '{1, 2, 3, 5};

  // output pattern {ctl[1:0], phy[1:0], ana, dig, ready}
  localparam logic [6:0] P_HOLD = 7'b11_11_000;
  localparam logic [6:0] P_GAP  = 7'b11_00_000;
  localparam logic [6:0] P_SETL = 7'b00_00_000;
  localparam logic [6:0] P_ANA  = 7'b00_00_100;
  localparam logic [6:0] P_DONE = 7'b00_00_111;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
  logic [1:0] ctl_rst, phy_rst;
  logic ana, dig, ready;
  int cyc = 0, nchk = 0, nfail = 0;
  int n_hold, n_gap, n_settle, n_ana, n_tick, n_bad, n_done;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_rst_seq #(.HOLD_CYC(HOLD), .PHY2CTL_CYC(GAP), .SETTLE_CYC(SETTLE),
                .ANA2DIG_TICKS(TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dram_tick_i(tick),
    .ctl_rst_o(ctl_rst), .phy_rst_o(phy_rst), .phy_ana_rel_o(ana),
    .phy_dig_rel_o(dig), .ready_o(ready)
  );

  function automatic logic [6:0] pat();
    return {ctl_rst, phy_rst, ana, dig, ready};
  endfunction

  function automatic int phase_of(input logic [6:0] p);
    if (p == P_HOLD) return 1;
    if (p == P_GAP)  return 2;
    if (p == P_SETL) return 3;
    if (p == P_ANA)  return 4;
    if (p == P_DONE) return 5;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    tick  = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // walks the phases from the current negedge; per = 0 means no ticks
  task automatic walk(input int per, input int max_cyc);
    int ph;
    ph = 0;
    n_hold = 0; n_gap = 0; n_settle = 0; n_ana = 0; n_tick = 0; n_bad = 0; n_done = 0;
    for (int i = 0; i < max_cyc; i++) begin
      int cur;
      cur = phase_of(pat());
      if (cur < 0 || cur < ph) n_bad++;
      else ph = cur;
      if (cur == 5) begin
        n_done = 1;
        tick = 1'b0;
        break;
      end
      if (cur == 1) n_hold++;
      if (cur == 2) n_gap++;
      if (cur == 3) n_settle++;
      if (cur == 4) n_ana++;
      tick = (per > 0) && ((cyc % per) == 0);
      if (cur == 4 && tick) n_tick++;
      @(negedge clk);
    end
  endtask

  task automatic check_full(input string tag);
    check({tag, " R8 done"}, n_done, 1);
    check({tag, " R3 hold"}, n_hold, HOLD);
    check({tag, " R4 phy-ctl gap"}, n_gap, GAP);
    check({tag, " R5 settle"}, n_settle, SETTLE);
    check({tag, " R6 ticks"}, n_tick, TICKS);
    check({tag, " R6 ana cycles>=ticks"}, int'(n_ana >= TICKS), 1);
    check({tag, " R7 order"}, n_bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R8: watchdog actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(pat()), int'(P_HOLD));
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tick = 1'b1;
      if (pat() != P_HOLD) bad++;
    end
    tick = 1'b0;
    check("R1 idle ignores ticks", bad, 0);

    // table walk over tick spacings
    for (int v = 0; v < NPER; v++) begin
      pulse_start();
      walk(PERIODS[v], 500);
      check_full($sformatf("vec%0d", v));
    end

    // R8: ready holds, ticks ignored
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tick = i[0];
      @(negedge clk);
      if (pat() != P_DONE) bad++;
    end
    tick = 1'b0;
    check("R8 ready holds", bad, 0);

    // R10 + R2: restart from done
    pulse_start();
    check("R2 restart from done", int'(pat()), int'(P_HOLD));
    walk(2, 500);
    check_full("R10 after done");

    // R9: no ticks, stalls in analog-only phase
    pulse_start();
    walk(0, HOLD + GAP + SETTLE + 3);
    check("R9 reaches analog wait", phase_of(pat()), 4);
    repeat (50) @(negedge clk);
    check("R9 digital held", int'(pat()), int'(P_ANA));

    // R10: restart during analog wait
    pulse_start();
    check("R10 restart in ana", int'(pat()), int'(P_HOLD));
    walk(1, 500);
    check_full("R10 from ana");

    // R2: start held high during the PHY gap
    pulse_start();
    walk(1, HOLD + 2);
    check("R2 in phy gap", phase_of(pat()), 2);
    start = 1'b1;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (pat() != P_HOLD) bad++;
    end
    start = 1'b0;
    check("R2 held start keeps all asserted", bad, 0);
    walk(3, 500);
    check_full("R10 from gap");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule